// File: doc/BRIEF.md
# Highest Priority Pending Interrupt Selector

This block keeps the pending and active state of a bank of shared interrupt lines. Each cycle it picks the single most urgent line that may be signalled. Line `i` of the bank carries interrupt ID `32 + i`, so the bank covers IDs 32 through `NUM_LINES - 1`. Hardware sources pulse `irq_assert` to raise a line and pulse `irq_deassert` to withdraw it. Per-line enables, 8-bit priority values, 2-bit group classes and a per-group enable mask come in as flat vectors.

The selected ID and its priority are presented from a register. A consumer takes the presented interrupt with `ack`, which turns it from pending to active. The consumer later retires it with `eoi` and the ID, which clears the active bit. A 2-bit status per line exposes the stored state.

Top module: `hpi_selector`

## Requirements
- R1: A line is a candidate only when it is pending, its `irq_enable` bit is 1, it is not active, and `group_en[class]` is 1 for its 2-bit class in `irq_group`.
- R2: Among the candidates, the one with the numerically smallest priority value is selected.
- R3: When candidates share the smallest priority value, the one with the lowest interrupt ID is selected.
- R4: Line `i` maps to interrupt ID `32 + i`, and `hpp_id` reports that ID for IDs 32 through `NUM_LINES - 1`.
- R5: With no candidate, `hpp_valid` is 0, `hpp_id` is 1023 and `hpp_prio` is 0xFF.
- R6: An `irq_assert` pulse sets the pending bit at the clock edge where it is sampled. The selection outputs reflect the stored state one edge later.
- R7: `ack` while `hpp_valid` is 1 clears the pending bit and sets the active bit of the presented line at that edge, and drops `hpp_valid` at the same edge. An `irq_assert` on the same line in the same cycle leaves it both active and pending.
- R8: `eoi` with `eoi_id` in 32 through `NUM_LINES - 1` clears that line's active bit and leaves its pending bit unchanged. An `eoi_id` outside that range changes nothing.
- R9: `irq_status[2i+1:2i]` is {active, pending}: 00 inactive, 01 pending only, 10 active only, 11 active and pending.
- R10: `irq_deassert` clears the pending bit and wins over `irq_assert` in the same cycle. The selection is then re-evaluated.
- R11: Synchronous reset clears all pending and active bits and drives the outputs to the no-candidate values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_assert | input | NUM_LINES-32 | Per-line pulse that sets pending |
| irq_deassert | input | NUM_LINES-32 | Per-line pulse that clears pending |
| irq_enable | input | NUM_LINES-32 | Per-line enable |
| irq_prio | input | (NUM_LINES-32)*PRIO_W | Priority value per line, line i at bits [i*PRIO_W +: PRIO_W] |
| irq_group | input | (NUM_LINES-32)*2 | Group class per line, line i at bits [2i +: 2] |
| group_en | input | NUM_GROUPS | Enable per group class |
| ack | input | 1 | Take the presented interrupt |
| eoi | input | 1 | Retire the interrupt named by eoi_id |
| eoi_id | input | 10 | Interrupt ID to retire |
| hpp_valid | output | 1 | A candidate is presented |
| hpp_id | output | 10 | Presented interrupt ID, 1023 when none |
| hpp_prio | output | PRIO_W | Presented priority, all ones when none |
| irq_status | output | (NUM_LINES-32)*2 | {active, pending} per line |

## Verification
Acknowledge and a fresh hardware assert can land on the same line in the same cycle. The bench drives `ack` while line 3 is presented and pulses `irq_assert[3]` in that same cycle. It then expects status 11 for that line and no candidate on the following cycle, because the line is active. The bench also places a deassert and an assert on one line in the same cycle, and expects the line to end inactive.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  localparam int FIRST_ID = 32;
  localparam int ID_W     = 10;
  localparam logic [ID_W-1:0] NONE_ID = 10'd1023;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PEND = 2'b01,
    ST_ACT  = 2'b10,
    ST_BOTH = 2'b11
  } line_state_e;
endpackage

// File: rtl/hpi_line_state.sv
module hpi_line_state #(
  parameter int N = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   set_pend,
  input  logic [N-1:0]   clr_pend,
  input  logic [N-1:0]   take,
  input  logic [N-1:0]   retire,
  output logic [N-1:0]   pend,
  output logic [N-1:0]   act,
  output logic [2*N-1:0] status
);
  // Deassert outranks assert; a new assert outranks the clear done by take.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      act  <= '0;
    end else begin
      pend <= ((pend & ~take) | set_pend) & ~clr_pend;
      act  <= (act & ~retire) | take;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_stat
    assign status[2*i +: 2] = {act[i], pend[i]};
  end
endmodule

// File: rtl/hpi_pick_tree.sv
module hpi_pick_tree #(
  parameter int N      = 32,
  parameter int PRIO_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        elig,
  input  logic [N*PRIO_W-1:0] prio_flat,
  output logic                found,
  output logic [IDX_W-1:0]    idx,
  output logic [PRIO_W-1:0]   prio
);
  localparam int LVL    = $clog2(N);
  localparam int LEAVES = 1 << LVL;
  localparam int NODES  = 2 * LEAVES - 1;

  logic              nd_v [NODES];
  logic [PRIO_W-1:0] nd_p [NODES];
  logic [IDX_W-1:0]  nd_i [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < N) begin : g_real
      assign nd_v[LEAVES-1+j] = elig[j];
      assign nd_p[LEAVES-1+j] = prio_flat[j*PRIO_W +: PRIO_W];
      assign nd_i[LEAVES-1+j] = IDX_W'(j);
    end else begin : g_pad
      assign nd_v[LEAVES-1+j] = 1'b0;
      assign nd_p[LEAVES-1+j] = '1;
      assign nd_i[LEAVES-1+j] = '0;
    end
  end

  // Left subtree always holds lower IDs, so ties go left.
  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    logic take_left;
    assign take_left = nd_v[2*k+1] &&
                       (!nd_v[2*k+2] || (nd_p[2*k+1] <= nd_p[2*k+2]));
    assign nd_v[k] = nd_v[2*k+1] | nd_v[2*k+2];
    assign nd_p[k] = take_left ? nd_p[2*k+1] : nd_p[2*k+2];
    assign nd_i[k] = take_left ? nd_i[2*k+1] : nd_i[2*k+2];
  end

  assign found = nd_v[0];
  assign idx   = nd_i[0];
  assign prio  = nd_p[0];
endmodule

// File: rtl/hpi_selector.sv
module hpi_selector
  import hpi_pkg::*;
#(
  parameter int NUM_LINES  = 64,
  parameter int PRIO_W     = 8,
  parameter int NUM_GROUPS = 4,
  localparam int NSRC  = NUM_LINES - FIRST_ID,
  localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSRC-1:0]        irq_assert,
  input  logic [NSRC-1:0]        irq_deassert,
  input  logic [NSRC-1:0]        irq_enable,
  input  logic [NSRC*PRIO_W-1:0] irq_prio,
  input  logic [NSRC*GRP_W-1:0]  irq_group,
  input  logic [NUM_GROUPS-1:0]  group_en,
  input  logic                   ack,
  input  logic                   eoi,
  input  logic [ID_W-1:0]        eoi_id,
  output logic                   hpp_valid,
  output logic [ID_W-1:0]        hpp_id,
  output logic [PRIO_W-1:0]      hpp_prio,
  output logic [2*NSRC-1:0]      irq_status
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]   pend, act, elig, ack_hit, eoi_hit;
  logic              found;
  logic [IDX_W-1:0]  pick_idx, win_idx_q;
  logic [PRIO_W-1:0] pick_prio;
  logic              ack_take;
  logic              eoi_in_range;
  logic [ID_W-1:0]   eoi_off;

  assign ack_take     = ack && hpp_valid;
  assign eoi_in_range = eoi && (eoi_id >= ID_W'(FIRST_ID)) &&
                        (eoi_id < ID_W'(NUM_LINES));
  assign eoi_off      = eoi_id - ID_W'(FIRST_ID);

  for (genvar i = 0; i < NSRC; i++) begin : g_line
    assign ack_hit[i] = ack_take && (win_idx_q == IDX_W'(i));
    assign eoi_hit[i] = eoi_in_range && (eoi_off == ID_W'(i));
    assign elig[i]    = pend[i] && irq_enable[i] && !act[i] &&
                        group_en[irq_group[i*GRP_W +: GRP_W]];
  end

  hpi_line_state #(.N(NSRC)) u_state (
    .clk      (clk),
    .rst      (rst),
    .set_pend (irq_assert),
    .clr_pend (irq_deassert),
    .take     (ack_hit),
    .retire   (eoi_hit),
    .pend     (pend),
    .act      (act),
    .status   (irq_status)
  );

  hpi_pick_tree #(.N(NSRC), .PRIO_W(PRIO_W)) u_tree (
    .elig      (elig),
    .prio_flat (irq_prio),
    .found     (found),
    .idx       (pick_idx),
    .prio      (pick_prio)
  );

  // Registered result; an acknowledge blanks it for one cycle so the
  // taken line is never presented twice.
  always_ff @(posedge clk) begin
    if (rst) begin
      hpp_valid <= 1'b0;
      hpp_id    <= NONE_ID;
      hpp_prio  <= '1;
      win_idx_q <= '0;
    end else if (ack_take) begin
      hpp_valid <= 1'b0;
      hpp_id    <= NONE_ID;
      hpp_prio  <= '1;
    end else begin
      hpp_valid <= found;
      hpp_id    <= found ? (ID_W'(FIRST_ID) + ID_W'(pick_idx)) : NONE_ID;
      hpp_prio  <= found ? pick_prio : '1;
      win_idx_q <= pick_idx;
    end
  end
endmodule

// File: rtl/hpi_selector_chk.sv
module hpi_selector_chk
  import hpi_pkg::*;
#(
  parameter int NUM_LINES  = 64,
  parameter int PRIO_W     = 8,
  parameter int NUM_GROUPS = 4,
  localparam int NSRC  = NUM_LINES - FIRST_ID,
  localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NSRC-1:0]        irq_assert,
  input logic [NSRC-1:0]        irq_deassert,
  input logic [NSRC-1:0]        irq_enable,
  input logic [NSRC*PRIO_W-1:0] irq_prio,
  input logic [NSRC*GRP_W-1:0]  irq_group,
  input logic [NUM_GROUPS-1:0]  group_en,
  input logic                   ack,
  input logic                   eoi,
  input logic [ID_W-1:0]        eoi_id,
  input logic                   hpp_valid,
  input logic [ID_W-1:0]        hpp_id,
  input logic [PRIO_W-1:0]      hpp_prio,
  input logic [2*NSRC-1:0]      irq_status
);
  // R5
  no_candidate_id_chk: assert property (@(posedge clk) disable iff (rst)
    !hpp_valid |-> (hpp_id == NONE_ID && hpp_prio == '1));

  // R7
  ack_blanks_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && hpp_valid) |=> !hpp_valid);

  for (genvar i = 0; i < NSRC; i++) begin : g_line
    // R1
    winner_eligible_chk: assert property (@(posedge clk) disable iff (rst)
      (hpp_valid && hpp_id == ID_W'(FIRST_ID + i)) |->
        ($past(irq_status[2*i +: 2]) == ST_PEND && $past(irq_enable[i])));

    // R7
    ack_sets_active_chk: assert property (@(posedge clk) disable iff (rst)
      (ack && hpp_valid && hpp_id == ID_W'(FIRST_ID + i)) |=> irq_status[2*i+1]);

    // R8
    eoi_clears_active_chk: assert property (@(posedge clk) disable iff (rst)
      (eoi && eoi_id == ID_W'(FIRST_ID + i) &&
       !(ack && hpp_valid && hpp_id == ID_W'(FIRST_ID + i))) |=> !irq_status[2*i+1]);

    // R10
    deassert_clears_chk: assert property (@(posedge clk) disable iff (rst)
      irq_deassert[i] |=> !irq_status[2*i]);
  end
endmodule

bind hpi_selector hpi_selector_chk #(
  .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .NUM_GROUPS(NUM_GROUPS)
) u_chk (
  .clk(clk), .rst(rst), .irq_assert(irq_assert), .irq_deassert(irq_deassert),
  .irq_enable(irq_enable), .irq_prio(irq_prio), .irq_group(irq_group),
  .group_en(group_en), .ack(ack), .eoi(eoi), .eoi_id(eoi_id),
  .hpp_valid(hpp_valid), .hpp_id(hpp_id), .hpp_prio(hpp_prio),
  .irq_status(irq_status)
);

// File: tb/test_hpi_selector.sv
module test_hpi_selector;
  localparam int N = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    irq_assert = '0, irq_deassert = '0, irq_enable = '1;
  logic [N*8-1:0]  irq_prio;
  logic [N*2-1:0]  irq_group = '0;
  logic [3:0]      group_en = 4'hF;
  logic            ack = 1'b0, eoi = 1'b0;
  logic [9:0]      eoi_id = '0;
  logic            hpp_valid;
  logic [9:0]      hpp_id;
  logic [7:0]      hpp_prio;
  logic [2*N-1:0]  irq_status;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  hpi_selector i_hpi_selector (
    .clk(clk), .rst(rst), .irq_assert(irq_assert), .irq_deassert(irq_deassert),
    .irq_enable(irq_enable), .irq_prio(irq_prio), .irq_group(irq_group),
    .group_en(group_en), .ack(ack), .eoi(eoi), .eoi_id(eoi_id),
    .hpp_valid(hpp_valid), .hpp_id(hpp_id), .hpp_prio(hpp_prio),
    .irq_status(irq_status)
  );

  // {assert mask, expected ID}; priority of line i is 15 - i/2
  localparam logic [41:0] VEC [0:7] = '{
    {32'h0000_0001, 10'd32},   // R4 lowest ID
    {32'h0000_0003, 10'd32},   // R3 tie
    {32'h8000_0001, 10'd63},   // R2, R4 highest ID
    {32'hC000_0000, 10'd62},   // R3 tie at top
    {32'h0000_0000, 10'd1023}, // R5 none
    {32'h00F0_0000, 10'd54},   // R2, R3
    {32'h0000_0100, 10'd40},   // R2
    {32'h5555_5555, 10'd62}    // R2
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] actual, logic [31:0] expected);
    n_chk++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, actual, expected);
    end
  endtask

  task automatic pulse_assert(logic [N-1:0] m);
    irq_assert = m; tick(); irq_assert = '0;
  endtask

  task automatic pulse_deassert(logic [N-1:0] m);
    irq_deassert = m; tick(); irq_deassert = '0;
  endtask

  task automatic do_eoi(logic [9:0] id);
    eoi = 1'b1; eoi_id = id; tick(); eoi = 1'b0;
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [31:0] exp_prio(logic [9:0] id);
    return (id == 10'd1023) ? 32'hFF : 32'(15 - (id - 32) / 2);
  endfunction

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    for (int i = 0; i < N; i++) irq_prio[i*8 +: 8] = 8'(15 - i / 2);
    @(negedge clk);
    tick(); tick();
    chk("R11 reset valid", 32'(hpp_valid), 0);
    chk("R11 reset id", 32'(hpp_id), 1023);
    chk("R11 reset status", 32'(|irq_status), 0);
    rst = 1'b0;
    tick();

    for (int v = 0; v < 8; v++) begin
      logic [31:0] m;
      logic [9:0]  e;
      m = VEC[v][41:10];
      e = VEC[v][9:0];
      pulse_deassert('1);
      pulse_assert(m);
      tick();
      chk("R2/R3 table id", 32'(hpp_id), 32'(e));
      chk("R5 table valid", 32'(hpp_valid), 32'(e != 10'd1023));
      chk("R2 table prio", 32'(hpp_prio), exp_prio(e));
    end

    // R6 latency
    pulse_deassert('1);
    pulse_assert(32'h1 << 5);
    chk("R6 not yet visible", 32'(hpp_valid), 0);
    chk("R9 pending status", 32'(irq_status[11:10]), 32'b01);
    tick();
    chk("R6 visible", 32'(hpp_id), 37);

    // R1 enable
    irq_enable[31] = 1'b0;
    pulse_assert(32'h1 << 31);
    tick();
    chk("R1 disabled excluded", 32'(hpp_id), 37);
    irq_enable[31] = 1'b1;
    tick();
    chk("R1 enabled included", 32'(hpp_id), 63);
    pulse_deassert(32'h1 << 31);
    chk("R10 status cleared", 32'(irq_status[63:62]), 32'b00);
    tick();
    chk("R10 reselect", 32'(hpp_id), 37);

    // R1 group mask
    irq_group[11:10] = 2'd2;
    group_en[2] = 1'b0;
    tick(); tick();
    chk("R5 group off valid", 32'(hpp_valid), 0);
    chk("R5 group off id", 32'(hpp_id), 1023);
    chk("R5 group off prio", 32'(hpp_prio), 32'hFF);
    group_en = 4'hF;
    tick(); tick();
    chk("R1 group on", 32'(hpp_id), 37);

    // R7 acknowledge
    pulse_assert(32'h1 << 3);
    tick();
    chk("R2 before ack", 32'(hpp_id), 37);
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R7 valid drops", 32'(hpp_valid), 0);
    chk("R7 status active", 32'(irq_status[11:10]), 32'b10);
    tick();
    chk("R1 active excluded", 32'(hpp_id), 35);

    // R9 both
    pulse_assert(32'h1 << 5);
    chk("R9 both", 32'(irq_status[11:10]), 32'b11);
    tick();
    chk("R1 both excluded", 32'(hpp_id), 35);

    // R8 eoi
    do_eoi(10'd37);
    chk("R8 pending kept", 32'(irq_status[11:10]), 32'b01);
    tick();
    chk("R8 reselect", 32'(hpp_id), 37);

    // R8 out of range
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R7 second ack", 32'(irq_status[11:10]), 32'b10);
    do_eoi(10'd20);
    chk("R8 low id ignored", 32'(irq_status[11:10]), 32'b10);
    do_eoi(10'd1023);
    chk("R8 high id ignored", 32'(irq_status[11:10]), 32'b10);
    chk("R1 shows 35", 32'(hpp_id), 35);

    // R7 ack and assert on the same line in one cycle
    ack = 1'b1; irq_assert = 32'h1 << 3; tick();
    ack = 1'b0; irq_assert = '0;
    chk("R7 ack with assert", 32'(irq_status[7:6]), 32'b11);
    tick();
    chk("R7 none left", 32'(hpp_valid), 0);

    // R10 deassert wins
    irq_assert = 32'h1 << 7; irq_deassert = 32'h1 << 7; tick();
    irq_assert = '0; irq_deassert = '0;
    chk("R10 deassert wins", 32'(irq_status[15:14]), 32'b00);

    do_eoi(10'd35);
    chk("R8 35 pending kept", 32'(irq_status[7:6]), 32'b01);
    tick();
    chk("R8 35 reselected", 32'(hpp_id), 35);
    chk("R2 35 prio", 32'(hpp_prio), 14);

    // R11 mid-run reset
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R11 status cleared", 32'(|irq_status), 0);
    chk("R11 output cleared", 32'(hpp_valid), 0);
    chk("R11 id cleared", 32'(hpp_id), 1023);

    finish_up();
  end
endmodule